// File: doc/BRIEF.md
# Two-Level Trap Gate Vector Unit

This block carries out a gate-style entry into privileged code. When `start` is seen while the unit is idle, it captures the current program counter, status word and stack pointer, along with two selector values. It then saves the program counter and status word on an upward-growing execution stack. After that it walks a two-level vector structure in memory. A pointer table at address 0 supplies the base of a handler table. An indexed 8-byte handler entry supplies the new program counter and status word.

Both selectors pass through fixed masks into hidden registers before they are used. The caller's selector values are only sampled and never written back. All memory traffic goes through a single word port. Each access holds its request until the memory acknowledges it, so slow memory only lengthens the sequence. The new processor state is presented on the output ports in one update, and `done` is raised for one cycle while that state is first visible.

Top module: `trap_gate_unit`

## Requirements
- R1: The unit makes two writes before any read. It first writes the program counter at the captured stack pointer, then writes the status word at stack pointer + 4. The returned stack pointer equals the captured stack pointer + 8.
- R2: The first read uses the address `sel_a AND 0x0000007C`. This is a word-aligned pointer-table entry in the range 0 to 0x7C.
- R3: The word returned by the pointer-table read is the handler-table base. The handler program counter is read from base + (`sel_b AND 0x00007FF8`), and the handler status word from that address + 4.
- R4: `pc_out` and `psw_out` take the two handler words in the same clock edge. `done` is high for exactly one cycle, which is the first cycle in which the new values are visible. The outputs hold their values until the next completed sequence.
- R5: Selector bits outside the masks have no effect. Selectors that differ only in those bits produce the same accesses and the same results.
- R6: Several pointer-table entries that hold the same base reach the same handler entry, with no restriction.
- R7: A memory request keeps its address, write enable and write data stable until `mem_ack`. Each wait cycle delays completion by exactly one cycle. With zero wait states, `done` rises 11 clock edges after the edge that accepts `start`.
- R8: The five accesses always come in this fixed order: push program counter, push status word, pointer read, handler program counter read, handler status word read. No other memory access occurs during a sequence.
- R9: `start` is ignored while `busy` is high. It neither restarts nor adds accesses, and it does not change the results.
- R10: After reset, `busy`, `done` and `mem_req` are 0, and `pc_out`, `psw_out` and `sp_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a gate entry; sampled only when idle |
| pc_in | input | 32 | Current program counter |
| psw_in | input | 32 | Current status word |
| sp_in | input | 32 | Current execution stack pointer |
| sel_a | input | 32 | Pointer-table selector (masked with 0x7C) |
| sel_b | input | 32 | Handler-table selector (masked with 0x7FF8) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid while `mem_ack` is high |
| mem_ack | input | 1 | Access completes on a clock edge where `mem_req` and `mem_ack` are both high |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when the new state first appears |
| pc_out | output | 32 | Loaded program counter |
| psw_out | output | 32 | Loaded status word |
| sp_out | output | 32 | Stack pointer after the two pushes |

## Verification
With a memory that acknowledges one cycle after each request, every access takes two cycles. The commit follows the fifth acknowledge by one edge, and `done` is observed 11 edges after the accepting edge. With w wait states the figure is 5·(2+w)+1 edges. The bench drives and samples on the falling edge. It counts rising edges from the accepting edge until `done` is first seen, and compares that count with the formula. It reads the outputs in that same `done` cycle, and it checks the logged access order, addresses and write data once the pulse has arrived.

// File: rtl/trap_gate_pkg.sv
// Shared types for the trap gate unit.
// Assumes a byte-addressed memory with word-sized accesses.
package trap_gate_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PUSH_PC  = 3'd1,
        ST_PUSH_PSW = 3'd2,
        ST_RD_PTR   = 3'd3,
        ST_RD_HPC   = 3'd4,
        ST_RD_HPSW  = 3'd5,
        ST_COMMIT   = 3'd6,
        ST_DONE     = 3'd7
    } gate_state_e;

endpackage

// File: rtl/trap_gate_mask.sv
// Selector masking stage: forces a raw selector into its legal range.
// Purely combinational; the caller stores the result in its own hidden
// register so that the raw selector source is never written.
module trap_gate_mask #(
    parameter int          XLEN = 32,
    parameter logic [31:0] MASK = 32'h0000_007C
) (
    input  logic [XLEN-1:0] raw,
    output logic [XLEN-1:0] masked
);

    localparam logic [XLEN-1:0] MASK_W = XLEN'(MASK);

    // Apply the fixed mask
    always_comb masked = raw & MASK_W;

endmodule

// File: rtl/trap_gate_seq.sv
// Sequencer for the gate entry: walks the fixed access order and
// advances on each completed memory transfer.
// Assumes xfer_done is only high when a request is outstanding.
module trap_gate_seq
    import trap_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        xfer_done,
    output gate_state_e state,
    output logic        accept,
    output logic        busy,
    output logic        done
);

    gate_state_e state_nx;

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start)     state_nx = ST_PUSH_PC;
            ST_PUSH_PC:  if (xfer_done) state_nx = ST_PUSH_PSW;
            ST_PUSH_PSW: if (xfer_done) state_nx = ST_RD_PTR;
            ST_RD_PTR:   if (xfer_done) state_nx = ST_RD_HPC;
            ST_RD_HPC:   if (xfer_done) state_nx = ST_RD_HPSW;
            ST_RD_HPSW:  if (xfer_done) state_nx = ST_COMMIT;
            ST_COMMIT:                  state_nx = ST_DONE;
            ST_DONE:                    state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Status decodes
    always_comb begin
        accept = (state == ST_IDLE) && start;
        busy   = (state != ST_IDLE) && (state != ST_DONE);
        done   = (state == ST_DONE);
    end

endmodule

// File: rtl/trap_gate_datapath.sv
// Datapath for the gate entry: captures the caller state and masked
// selectors, forms each access address, collects the read words and
// loads the new processor state in a single edge at commit.
module trap_gate_datapath
    import trap_gate_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter logic [31:0] PTR_MASK = 32'h0000_007C,
    parameter logic [31:0] IDX_MASK = 32'h0000_7FF8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  gate_state_e     state,
    input  logic            accept,
    input  logic            xfer_done,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] psw_in,
    input  logic [XLEN-1:0] sp_in,
    input  logic [XLEN-1:0] sel_a,
    input  logic [XLEN-1:0] sel_b,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic [XLEN-1:0] pc_out,
    output logic [XLEN-1:0] psw_out,
    output logic [XLEN-1:0] sp_out
);

    localparam int            WORD_BYTES  = XLEN / 8;
    localparam logic [XLEN-1:0] WORD_STEP = XLEN'(WORD_BYTES);
    localparam logic [XLEN-1:0] PUSH_SPAN = XLEN'(2 * WORD_BYTES);
    localparam int            NUM_SEL     = 2;
    localparam logic [31:0]   MASKS [NUM_SEL] = '{PTR_MASK, IDX_MASK};

    logic [XLEN-1:0] sel_raw    [NUM_SEL];
    logic [XLEN-1:0] sel_masked [NUM_SEL];
    logic [XLEN-1:0] sel_q      [NUM_SEL];
    logic [XLEN-1:0] pc_q, psw_q, sp_q;
    logic [XLEN-1:0] base_q, hpc_q, hpsw_q;
    logic [XLEN-1:0] entry_addr;

    assign sel_raw[0] = sel_a;
    assign sel_raw[1] = sel_b;

    // One masking stage and hidden register per selector
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        trap_gate_mask #(
            .XLEN (XLEN),
            .MASK (MASKS[g])
        ) u_mask (
            .raw    (sel_raw[g]),
            .masked (sel_masked[g])
        );

        // Hold the masked selector for the whole sequence
        always_ff @(posedge clk) begin
            if (!rst_n)      sel_q[g] <= '0;
            else if (accept) sel_q[g] <= sel_masked[g];
        end
    end

    // Capture the caller's state when a sequence is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            psw_q <= '0;
            sp_q  <= '0;
        end else if (accept) begin
            pc_q  <= pc_in;
            psw_q <= psw_in;
            sp_q  <= sp_in;
        end
    end

    // Collect the words read from the two tables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            hpc_q  <= '0;
            hpsw_q <= '0;
        end else if (xfer_done) begin
            if (state == ST_RD_PTR)  base_q <= mem_rdata;
            if (state == ST_RD_HPC)  hpc_q  <= mem_rdata;
            if (state == ST_RD_HPSW) hpsw_q <= mem_rdata;
        end
    end

    assign entry_addr = base_q + sel_q[1];

    // Address, data and direction for the access of the current state
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_PUSH_PC: begin
                mem_we    = 1'b1;
                mem_addr  = sp_q;
                mem_wdata = pc_q;
            end
            ST_PUSH_PSW: begin
                mem_we    = 1'b1;
                mem_addr  = sp_q + WORD_STEP;
                mem_wdata = psw_q;
            end
            ST_RD_PTR:  mem_addr = sel_q[0];
            ST_RD_HPC:  mem_addr = entry_addr;
            ST_RD_HPSW: mem_addr = entry_addr + WORD_STEP;
            default:    mem_req  = 1'b0;
        endcase
    end

    // Load the new processor state in one edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_out  <= '0;
            psw_out <= '0;
            sp_out  <= '0;
        end else if (state == ST_COMMIT) begin
            pc_out  <= hpc_q;
            psw_out <= hpsw_q;
            sp_out  <= sp_q + PUSH_SPAN;
        end
    end

endmodule

// File: rtl/trap_gate_unit.sv
// Two-level trap gate vector unit, top level.
// Pushes PC and status word, reads a pointer-table entry, then reads an
// 8-byte handler entry and loads the new PC and status word together.
// Assumes memory completes an access on an edge with mem_req & mem_ack.
module trap_gate_unit
    import trap_gate_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter logic [31:0] PTR_MASK = 32'h0000_007C,
    parameter logic [31:0] IDX_MASK = 32'h0000_7FF8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] psw_in,
    input  logic [XLEN-1:0] sp_in,
    input  logic [XLEN-1:0] sel_a,
    input  logic [XLEN-1:0] sel_b,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_ack,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] pc_out,
    output logic [XLEN-1:0] psw_out,
    output logic [XLEN-1:0] sp_out
);

    gate_state_e state;
    logic        accept;
    logic        xfer_done;

    // A transfer completes when a held request is acknowledged
    always_comb xfer_done = mem_req && mem_ack;

    trap_gate_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .xfer_done (xfer_done),
        .state     (state),
        .accept    (accept),
        .busy      (busy),
        .done      (done)
    );

    trap_gate_datapath #(
        .XLEN     (XLEN),
        .PTR_MASK (PTR_MASK),
        .IDX_MASK (IDX_MASK)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .accept    (accept),
        .xfer_done (xfer_done),
        .pc_in     (pc_in),
        .psw_in    (psw_in),
        .sp_in     (sp_in),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .pc_out    (pc_out),
        .psw_out   (psw_out),
        .sp_out    (sp_out)
    );

endmodule

// File: rtl/trap_gate_unit_chk.sv
// Protocol and ordering checks for trap_gate_unit, bound to the top.
module trap_gate_unit_chk
    import trap_gate_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ack,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic            done,
    input logic [XLEN-1:0] pc_out,
    input logic [XLEN-1:0] psw_out,
    input gate_state_e     state
);

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_PTR && mem_req) |-> (mem_addr[XLEN-1:7] == '0 && mem_addr[1:0] == 2'b00)); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R7

    AST_READ_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && $past(mem_req && mem_we && mem_ack)) |-> (mem_addr[XLEN-1:7] == '0)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

    AST_PC_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc_out) |-> done); // R4

    AST_PSW_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(psw_out) |-> done); // R4

    AST_QUIET_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R8

endmodule

bind trap_gate_unit trap_gate_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (done),
    .pc_out    (pc_out),
    .psw_out   (psw_out),
    .state     (state)
);

// File: tb/trap_gate_unit_tb.sv
// Directed bench for trap_gate_unit: one task per scenario.
module trap_gate_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] pc_in = '0, psw_in = '0, sp_in = '0, sel_a = '0, sel_b = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, done;
    logic [31:0] pc_out, psw_out, sp_out;

    int n_chk = 0;
    int n_bad = 0;
    int wait_n = 0;
    int wcnt = 0;
    int cyc_total = 0;

    logic [31:0] mem [logic [31:0]];
    logic        log_we   [0:255];
    logic [31:0] log_addr [0:255];
    logic [31:0] log_data [0:255];
    int          log_n = 0;

    always #2 clk = ~clk;   // 250 MHz

    trap_gate_unit u_dut (
        .clk (clk), .rst_n (rst_n), .start (start),
        .pc_in (pc_in), .psw_in (psw_in), .sp_in (sp_in),
        .sel_a (sel_a), .sel_b (sel_b),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .mem_ack (mem_ack),
        .busy (busy), .done (done),
        .pc_out (pc_out), .psw_out (psw_out), .sp_out (sp_out)
    );

    // Memory model: acknowledges after wait_n extra cycles, logs every access
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            wcnt      <= 0;
        end else if (mem_req && !mem_ack) begin
            if (wcnt >= wait_n) begin
                mem_ack <= 1'b1;
                wcnt    <= 0;
                if (mem_we) mem[mem_addr] = mem_wdata;
                mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                if (log_n < 256) begin
                    log_we[log_n]   = mem_we;
                    log_addr[log_n] = mem_addr;
                    log_data[log_n] = mem_we ? mem_wdata : (mem.exists(mem_addr) ? mem[mem_addr] : 32'h0);
                    log_n = log_n + 1;
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (cyc_total > 100000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Start a sequence, count edges to done, check outputs in the done cycle
    task automatic run_gate(input logic [31:0] pc, psw, sp, a, b, input int w,
                            input logic [31:0] exp_pc, exp_psw, output int cyc);
        wait_n = w;
        @(negedge clk);
        pc_in = pc; psw_in = psw; sp_in = sp; sel_a = a; sel_b = b; start = 1'b1;
        @(posedge clk);
        cyc = 0;
        @(negedge clk);
        start = 1'b0;
        forever begin
            if (done) break;
            cyc = cyc + 1;
            if (cyc > 1000) break;
            @(negedge clk);
        end
        chk("R4 pc_out at done", pc_out, exp_pc);
        chk("R4 psw_out at done", psw_out, exp_psw);
        chk("R1 sp_out", sp_out, sp + 32'd8);
        @(negedge clk);
        chk("R4 done single cycle", {31'b0, done}, 32'd0);
        chk("R4 pc_out held", pc_out, exp_pc);
    endtask

    // Compare the five logged accesses against the required order
    task automatic chk_log(input int base, input logic [31:0] pc, psw, sp, a, b, hbase);
        logic [31:0] ent;
        ent = hbase + (b & 32'h7FF8);
        chk("R8 access count", log_n - base, 32'd5);
        chk("R1 push pc we",   {31'b0, log_we[base]},   32'd1);
        chk("R1 push pc addr", log_addr[base],          sp);
        chk("R1 push pc data", log_data[base],          pc);
        chk("R1 push psw we",  {31'b0, log_we[base+1]}, 32'd1);
        chk("R1 push psw addr", log_addr[base+1],       sp + 32'd4);
        chk("R1 push psw data", log_data[base+1],       psw);
        chk("R2 ptr read we",  {31'b0, log_we[base+2]}, 32'd0);
        chk("R2 ptr read addr", log_addr[base+2],       a & 32'h7C);
        chk("R3 hpc read addr", log_addr[base+3],       ent);
        chk("R3 hpsw read addr", log_addr[base+4],      ent + 32'd4);
        chk("R8 reads not writes", {30'b0, log_we[base+3], log_we[base+4]}, 32'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R10 busy", {31'b0, busy}, 32'd0);
        chk("R10 done", {31'b0, done}, 32'd0);
        chk("R10 mem_req", {31'b0, mem_req}, 32'd0);
        chk("R10 pc_out", pc_out, 32'd0);
        chk("R10 psw_out", psw_out, 32'd0);
        chk("R10 sp_out", sp_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_basic();
        int b0, c;
        b0 = log_n;
        run_gate(32'h2222_0000, 32'h0000_00A5, 32'h1000, 32'h4, 32'h20, 0,
                 32'h4000_0100, 32'h0000_0003, c);
        chk("R7 zero-wait latency", c, 32'd11);
        chk_log(b0, 32'h2222_0000, 32'h0000_00A5, 32'h1000, 32'h4, 32'h20, 32'h3000);
        chk("R1 stacked pc", mem[32'h1000], 32'h2222_0000);
        chk("R1 stacked psw", mem[32'h1004], 32'h0000_00A5);
    endtask

    task automatic t_mask();
        int b0, c;
        b0 = log_n;
        run_gate(32'h1111_0000, 32'h0000_0011, 32'h1800, 32'hFFFF_FF87, 32'hFFFF_8027, 0,
                 32'h4000_0100, 32'h0000_0003, c);
        chk_log(b0, 32'h1111_0000, 32'h0000_0011, 32'h1800, 32'h4, 32'h20, 32'h3000);
        chk("R5 masked ptr addr", log_addr[b0+2], 32'h4);
        b0 = log_n;
        run_gate(32'h5, 32'h6, 32'h2000, 32'h7C, 32'h7FF8, 0,
                 32'hCAFE_0000, 32'h0000_0077, c);
        chk_log(b0, 32'h5, 32'h6, 32'h2000, 32'h7C, 32'h7FF8, 32'h8000);
        chk("R5 top handler entry", log_addr[b0+3], 32'hFFF8);
    endtask

    task automatic t_shared();
        int b0, c;
        b0 = log_n;
        run_gate(32'h7, 32'h8, 32'h2400, 32'h10, 32'h20, 0,
                 32'h4000_0100, 32'h0000_0003, c);
        chk_log(b0, 32'h7, 32'h8, 32'h2400, 32'h10, 32'h20, 32'h3000);
        chk("R6 shared base entry", log_addr[b0+3], 32'h3020);
    endtask

    task automatic t_wait();
        int b0, c;
        b0 = log_n;
        run_gate(32'h9, 32'hA, 32'h2800, 32'h4, 32'h28, 3,
                 32'h5555_0000, 32'h0000_0044, c);
        chk("R7 wait-state latency", c, 32'd26);
        chk_log(b0, 32'h9, 32'hA, 32'h2800, 32'h4, 32'h28, 32'h3000);
        wait_n = 0;
    endtask

    task automatic t_busy_start();
        int b0, c;
        b0 = log_n;
        wait_n = 0;
        @(negedge clk);
        pc_in = 32'hB; psw_in = 32'hC; sp_in = 32'h3000_0000; sel_a = 32'h4; sel_b = 32'h20; start = 1'b1;
        @(negedge clk);
        start = 1'b1; sel_a = 32'h7C; sel_b = 32'h7FF8; pc_in = 32'hDEAD; sp_in = 32'h0;
        repeat (4) @(negedge clk);
        start = 1'b0;
        c = 0;
        while (!done && c < 1000) begin
            @(negedge clk);
            c = c + 1;
        end
        chk("R9 pc_out unaffected", pc_out, 32'h4000_0100);
        chk("R9 sp_out unaffected", sp_out, 32'h3000_0008);
        chk_log(b0, 32'hB, 32'hC, 32'h3000_0000, 32'h4, 32'h20, 32'h3000);
        repeat (4) @(negedge clk);
        chk("R9 no extra accesses", log_n - b0, 32'd5);
        chk("R9 idle after", {31'b0, busy}, 32'd0);
    endtask

    initial begin
        mem[32'h04]   = 32'h3000;
        mem[32'h10]   = 32'h3000;
        mem[32'h7C]   = 32'h8000;
        mem[32'h3020] = 32'h4000_0100;
        mem[32'h3024] = 32'h0000_0003;
        mem[32'h3028] = 32'h5555_0000;
        mem[32'h302C] = 32'h0000_0044;
        mem[32'hFFF8] = 32'hCAFE_0000;
        mem[32'hFFFC] = 32'h0000_0077;
        t_reset();
        t_basic();
        t_mask();
        t_shared();
        t_wait();
        t_busy_start();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule